// File: doc/BRIEF.md
# Masked Bit-Serial Processing Grid

This block is a rectangular grid of one-bit processing elements wired as a two-dimensional torus. Every element sees the same micro-instruction on every cycle: an operand select, a neighbour direction, a broadcast bit, a shared local-memory bit address and update controls for three one-bit registers. The registers are an accumulator Q, a carry C and an activity flag A. Each element owns a small bit-addressable memory. A full adder takes Q, C and one operand. The operand comes from a multiplexer that can pick the element's own memory bit, its Q, its A, the C register of one torus neighbour, or the broadcast bit.

The adder sum or the raw operand can be written back to memory at the shared address. An element whose A flag is clear skips that write, so a controller can run arithmetic across a whole bit plane on a chosen subset of elements. For loading the array, a plane-wide port writes one bit into every element at the shared address. That port does not look at A. Row and column OR buses reduce a selected plane, so the controller can test for any set bit in each row and each column. The Q, C and A planes and the memory plane at the current address are also visible as flat vectors.

Top module: `bitpe_grid`

## Requirements
- R1: After reset, every Q and C is 0, every A is 1, and every memory bit reads 0.
- R2: With Q control 1, Q takes Q xor C xor operand. With C control 1, C takes the majority of Q, C and operand. All updates use the values before the clock edge.
- R3: The operand select picks the memory bit at the shared address (0), Q (1), A (2), the selected neighbour's C (3) or the broadcast bit (4). Codes 5 to 7 give 0.
- R4: The neighbour direction picks the element in row-1 (0), column+1 (1), row+1 (2) or column-1 (3). Row and column indices wrap around the grid.
- R5: A memory write from the instruction happens only in elements whose A was 1 before the edge. Q, C and A update in every element whatever A holds.
- R6: The write source writes the adder sum (0) or the operand (1) into memory at the shared address.
- R7: Q control: 0 hold, 1 sum, 2 operand, 3 clear. C control: 0 hold, 1 carry, 2 clear, 3 set. A control: 0 hold, 1 operand, 2 set, 3 clear.
- R8: While op_valid is low, Q, C, A and memory are left unchanged, except for a plane-port write.
- R9: When io_wr_en is high, bit r*COLS+c of io_wr_data is written to that element's memory at the shared address. This write ignores A and wins over an instruction write in the same cycle.
- R10: Bit r*COLS+c of rd_plane, q_plane, c_plane and a_plane belongs to the element in row r, column c. rd_plane shows memory at the current shared address.
- R11: row_or[r] and col_or[c] are the OR, along that row or column, of the plane chosen by obs_sel: Q (0), C (1), A (2) or memory at the shared address (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Micro-instruction active this cycle |
| opnd_sel | input | 3 | Operand select |
| nbr_dir | input | 2 | Neighbour direction for operand code 3 |
| bcast_bit | input | 1 | Bit broadcast to all elements |
| mem_addr | input | AW | Shared memory bit address |
| q_ctl | input | 2 | Q update control |
| c_ctl | input | 2 | C update control |
| a_ctl | input | 2 | A update control |
| wr_en | input | 1 | Instruction memory write enable |
| wr_src | input | 1 | Write source: 0 sum, 1 operand |
| io_wr_en | input | 1 | Plane-port write enable |
| io_wr_data | input | ROWS*COLS | Plane written by the plane port |
| obs_sel | input | 2 | Plane reduced onto the OR buses |
| rd_plane | output | ROWS*COLS | Memory plane at the shared address |
| q_plane | output | ROWS*COLS | Q register plane |
| c_plane | output | ROWS*COLS | C register plane |
| a_plane | output | ROWS*COLS | A register plane |
| row_or | output | ROWS | OR of the observed plane per row |
| col_or | output | COLS | OR of the observed plane per column |

## Verification
The bench places a single set C bit at an edge element and pulls it through each neighbour direction. A torus that fails to wrap, or that has north and south swapped, moves the bit to the wrong place or drops it. Writes are issued with an A plane loaded from memory. A mask that reads A after its own update, or that also gates the plane port, leaves memory wrong in exactly the masked elements. A long random sweep of every control and operand code, including the unused operand codes, is compared against an arithmetic model, which catches carry or sum slips and row/column swaps on the OR buses.

// File: rtl/bitpe_pkg.sv
package bitpe_pkg;

   typedef enum logic [2:0] {
      OPND_MEM   = 3'd0,
      OPND_Q     = 3'd1,
      OPND_A     = 3'd2,
      OPND_NBR   = 3'd3,
      OPND_BCAST = 3'd4
   } opnd_e;

   typedef enum logic [1:0] {
      DIR_NORTH = 2'd0,
      DIR_EAST  = 2'd1,
      DIR_SOUTH = 2'd2,
      DIR_WEST  = 2'd3
   } dir_e;

   typedef enum logic [1:0] {
      QC_HOLD = 2'd0,
      QC_SUM  = 2'd1,
      QC_OPND = 2'd2,
      QC_CLR  = 2'd3
   } q_ctl_e;

   typedef enum logic [1:0] {
      CC_HOLD  = 2'd0,
      CC_CARRY = 2'd1,
      CC_CLR   = 2'd2,
      CC_SET   = 2'd3
   } c_ctl_e;

   typedef enum logic [1:0] {
      AC_HOLD = 2'd0,
      AC_OPND = 2'd1,
      AC_SET  = 2'd2,
      AC_CLR  = 2'd3
   } a_ctl_e;

   typedef enum logic [1:0] {
      OBS_Q   = 2'd0,
      OBS_C   = 2'd1,
      OBS_A   = 2'd2,
      OBS_MEM = 2'd3
   } obs_e;

endpackage

// File: rtl/bitpe_fadd.sv
module bitpe_fadd (
   input  logic a_i,
   input  logic b_i,
   input  logic c_i,
   output logic sum_o,
   output logic cy_o
);
   always_comb begin
      sum_o = a_i ^ b_i ^ c_i;
      cy_o  = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
   end
endmodule

// File: rtl/bitpe_cell.sv
module bitpe_cell
   import bitpe_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_valid,
   input  logic [2:0]    opnd_sel,
   input  logic          bcast_bit,
   input  logic          nbr_carry,
   input  logic [AW-1:0] mem_addr,
   input  logic [1:0]    q_ctl,
   input  logic [1:0]    c_ctl,
   input  logic [1:0]    a_ctl,
   input  logic          wr_en,
   input  logic          wr_src,
   input  logic          io_wr_en,
   input  logic          io_bit,
   input  logic [1:0]    obs_sel,
   output logic          q_o,
   output logic          c_o,
   output logic          a_o,
   output logic          rd_o,
   output logic          obs_o
);
   logic [DEPTH-1:0] mem_q;
   logic             q_q, c_q, a_q;
   logic             opnd, sum, cy, wr_bit;

   assign rd_o = mem_q[mem_addr];

   always_comb begin
      case (opnd_e'(opnd_sel))
         OPND_MEM:   opnd = rd_o;
         OPND_Q:     opnd = q_q;
         OPND_A:     opnd = a_q;
         OPND_NBR:   opnd = nbr_carry;
         OPND_BCAST: opnd = bcast_bit;
         default:    opnd = 1'b0;
      endcase
   end

   bitpe_fadd u_fadd (
      .a_i   (q_q),
      .b_i   (c_q),
      .c_i   (opnd),
      .sum_o (sum),
      .cy_o  (cy)
   );

   assign wr_bit = wr_src ? opnd : sum;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_q   <= 1'b0;
         c_q   <= 1'b0;
         a_q   <= 1'b1;
         mem_q <= '0;
      end else begin
         if (op_valid) begin
            case (q_ctl_e'(q_ctl))
               QC_SUM:  q_q <= sum;
               QC_OPND: q_q <= opnd;
               QC_CLR:  q_q <= 1'b0;
               default: q_q <= q_q;
            endcase
            case (c_ctl_e'(c_ctl))
               CC_CARRY: c_q <= cy;
               CC_CLR:   c_q <= 1'b0;
               CC_SET:   c_q <= 1'b1;
               default:  c_q <= c_q;
            endcase
            case (a_ctl_e'(a_ctl))
               AC_OPND: a_q <= opnd;
               AC_SET:  a_q <= 1'b1;
               AC_CLR:  a_q <= 1'b0;
               default: a_q <= a_q;
            endcase
         end
         if (io_wr_en)
            mem_q[mem_addr] <= io_bit;
         else if (op_valid && wr_en && a_q)
            mem_q[mem_addr] <= wr_bit;
      end
   end

   always_comb begin
      case (obs_e'(obs_sel))
         OBS_Q:   obs_o = q_q;
         OBS_C:   obs_o = c_q;
         OBS_A:   obs_o = a_q;
         default: obs_o = rd_o;
      endcase
   end

   assign q_o = q_q;
   assign c_o = c_q;
   assign a_o = a_q;
endmodule

// File: rtl/bitpe_plane_or.sv
module bitpe_plane_or #(
   parameter int ROWS = 4,
   parameter int COLS = 4,
   localparam int N = ROWS * COLS
) (
   input  logic [N-1:0]    plane,
   output logic [ROWS-1:0] row_or,
   output logic [COLS-1:0] col_or
);
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign row_or[r] = |plane[r*COLS +: COLS];
   end

   for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [ROWS-1:0] col_bits;
      for (genvar r = 0; r < ROWS; r++) begin : g_pick
         assign col_bits[r] = plane[r*COLS + c];
      end
      assign col_or[c] = |col_bits;
   end
endmodule

// File: rtl/bitpe_grid.sv
module bitpe_grid
   import bitpe_pkg::*;
#(
   parameter int ROWS  = 4,
   parameter int COLS  = 4,
   parameter int DEPTH = 16,
   localparam int AW = $clog2(DEPTH),
   localparam int N  = ROWS * COLS
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            op_valid,
   input  logic [2:0]      opnd_sel,
   input  logic [1:0]      nbr_dir,
   input  logic            bcast_bit,
   input  logic [AW-1:0]   mem_addr,
   input  logic [1:0]      q_ctl,
   input  logic [1:0]      c_ctl,
   input  logic [1:0]      a_ctl,
   input  logic            wr_en,
   input  logic            wr_src,
   input  logic            io_wr_en,
   input  logic [N-1:0]    io_wr_data,
   input  logic [1:0]      obs_sel,
   output logic [N-1:0]    rd_plane,
   output logic [N-1:0]    q_plane,
   output logic [N-1:0]    c_plane,
   output logic [N-1:0]    a_plane,
   output logic [ROWS-1:0] row_or,
   output logic [COLS-1:0] col_or
);
   if (ROWS < 2 || COLS < 2) begin : g_bad_dims
      $error("bitpe_grid: ROWS and COLS must both be at least 2");
   end
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("bitpe_grid: DEPTH must be a power of two, at least 2");
   end

   logic [N-1:0] nbr_c;
   logic [N-1:0] obs_plane;

   for (genvar r = 0; r < ROWS; r++) begin : g_r
      for (genvar c = 0; c < COLS; c++) begin : g_c
         localparam int IDX = r*COLS + c;
         localparam int NI  = ((r + ROWS - 1) % ROWS)*COLS + c;
         localparam int EI  = r*COLS + (c + 1) % COLS;
         localparam int SI  = ((r + 1) % ROWS)*COLS + c;
         localparam int WI  = r*COLS + (c + COLS - 1) % COLS;

         always_comb begin
            case (dir_e'(nbr_dir))
               DIR_NORTH: nbr_c[IDX] = c_plane[NI];
               DIR_EAST:  nbr_c[IDX] = c_plane[EI];
               DIR_SOUTH: nbr_c[IDX] = c_plane[SI];
               default:   nbr_c[IDX] = c_plane[WI];
            endcase
         end

         bitpe_cell #(.DEPTH(DEPTH)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .op_valid  (op_valid),
            .opnd_sel  (opnd_sel),
            .bcast_bit (bcast_bit),
            .nbr_carry (nbr_c[IDX]),
            .mem_addr  (mem_addr),
            .q_ctl     (q_ctl),
            .c_ctl     (c_ctl),
            .a_ctl     (a_ctl),
            .wr_en     (wr_en),
            .wr_src    (wr_src),
            .io_wr_en  (io_wr_en),
            .io_bit    (io_wr_data[IDX]),
            .obs_sel   (obs_sel),
            .q_o       (q_plane[IDX]),
            .c_o       (c_plane[IDX]),
            .a_o       (a_plane[IDX]),
            .rd_o      (rd_plane[IDX]),
            .obs_o     (obs_plane[IDX])
         );
      end
   end

   bitpe_plane_or #(.ROWS(ROWS), .COLS(COLS)) u_or (
      .plane  (obs_plane),
      .row_or (row_or),
      .col_or (col_or)
   );
endmodule

// File: rtl/bitpe_grid_chk.sv
module bitpe_grid_chk #(
   parameter int ROWS  = 4,
   parameter int COLS  = 4,
   parameter int DEPTH = 16,
   localparam int AW = $clog2(DEPTH),
   localparam int N  = ROWS * COLS
) (
   input logic            clk,
   input logic            rst_n,
   input logic            op_valid,
   input logic [2:0]      opnd_sel,
   input logic [1:0]      nbr_dir,
   input logic            bcast_bit,
   input logic [AW-1:0]   mem_addr,
   input logic [1:0]      q_ctl,
   input logic            wr_en,
   input logic            io_wr_en,
   input logic [N-1:0]    io_wr_data,
   input logic [N-1:0]    rd_plane,
   input logic [N-1:0]    q_plane,
   input logic [N-1:0]    c_plane,
   input logic [N-1:0]    a_plane,
   input logic [ROWS-1:0] row_or,
   input logic [COLS-1:0] col_or
);
   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_valid) |=> ($stable(q_plane) && $stable(c_plane) && $stable(a_plane)));

   assert_plane_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      io_wr_en |=> (!$stable(mem_addr) || rd_plane == $past(io_wr_data)));

   assert_all_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && wr_en && !io_wr_en && a_plane == '0)
      |=> (!$stable(mem_addr) || $stable(rd_plane)));

   assert_bus_agree_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (|row_or) == (|col_or));

   assert_bcast_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && q_ctl == 2'd1 && opnd_sel == 3'd4)
      |=> q_plane == $past(q_plane ^ c_plane ^ {N{bcast_bit}}));

   for (genvar r = 0; r < ROWS; r++) begin : g_r
      for (genvar c = 0; c < COLS; c++) begin : g_c
         localparam int IDX = r*COLS + c;
         localparam int EI  = r*COLS + (c + 1) % COLS;
         assert_east_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && opnd_sel == 3'd3 && nbr_dir == 2'd1 && q_ctl == 2'd2)
            |=> q_plane[IDX] == $past(c_plane[EI]));
      end
   end
endmodule

bind bitpe_grid bitpe_grid_chk #(.ROWS(ROWS), .COLS(COLS), .DEPTH(DEPTH)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_valid   (op_valid),
   .opnd_sel   (opnd_sel),
   .nbr_dir    (nbr_dir),
   .bcast_bit  (bcast_bit),
   .mem_addr   (mem_addr),
   .q_ctl      (q_ctl),
   .wr_en      (wr_en),
   .io_wr_en   (io_wr_en),
   .io_wr_data (io_wr_data),
   .rd_plane   (rd_plane),
   .q_plane    (q_plane),
   .c_plane    (c_plane),
   .a_plane    (a_plane),
   .row_or     (row_or),
   .col_or     (col_or)
);

// File: tb/bitpe_grid_tb_top.sv
module bitpe_grid_tb_top;
   localparam int ROWS  = 4;
   localparam int COLS  = 4;
   localparam int DEPTH = 16;
   localparam int AW    = 4;
   localparam int N     = ROWS * COLS;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            op_valid;
   logic [2:0]      opnd_sel;
   logic [1:0]      nbr_dir;
   logic            bcast_bit;
   logic [AW-1:0]   mem_addr;
   logic [1:0]      q_ctl, c_ctl, a_ctl;
   logic            wr_en, wr_src, io_wr_en;
   logic [N-1:0]    io_wr_data;
   logic [1:0]      obs_sel;
   logic [N-1:0]    rd_plane, q_plane, c_plane, a_plane;
   logic [ROWS-1:0] row_or;
   logic [COLS-1:0] col_or;

   bit [N-1:0]     mq, mc, ma;
   bit [DEPTH-1:0] mm [N];
   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #4 clk = ~clk;

   bitpe_grid #(.ROWS(ROWS), .COLS(COLS), .DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opnd_sel(opnd_sel),
      .nbr_dir(nbr_dir), .bcast_bit(bcast_bit), .mem_addr(mem_addr),
      .q_ctl(q_ctl), .c_ctl(c_ctl), .a_ctl(a_ctl), .wr_en(wr_en),
      .wr_src(wr_src), .io_wr_en(io_wr_en), .io_wr_data(io_wr_data),
      .obs_sel(obs_sel), .rd_plane(rd_plane), .q_plane(q_plane),
      .c_plane(c_plane), .a_plane(a_plane), .row_or(row_or), .col_or(col_or)
   );

   task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic int nbr_idx(int i, logic [1:0] d);
      int r = i / COLS;
      int c = i % COLS;
      case (d)
         2'd0:    return ((r + ROWS - 1) % ROWS)*COLS + c;
         2'd1:    return r*COLS + (c + 1) % COLS;
         2'd2:    return ((r + 1) % ROWS)*COLS + c;
         default: return r*COLS + (c + COLS - 1) % COLS;
      endcase
   endfunction

   function automatic bit [N-1:0] exp_rd();
      bit [N-1:0] v;
      for (int i = 0; i < N; i++) v[i] = mm[i][mem_addr];
      return v;
   endfunction

   task automatic compare(string tag);
      bit [N-1:0] obs;
      bit [ROWS-1:0] er;
      bit [COLS-1:0] ec;
      case (obs_sel)
         2'd0:    obs = mq;
         2'd1:    obs = mc;
         2'd2:    obs = ma;
         default: obs = exp_rd();
      endcase
      er = '0;
      ec = '0;
      for (int i = 0; i < N; i++) begin
         er[i / COLS] |= obs[i];
         ec[i % COLS] |= obs[i];
      end
      chk({tag, " Q"}, q_plane, mq);
      chk({tag, " C"}, c_plane, mc);
      chk({tag, " A"}, a_plane, ma);
      chk({tag, " mem R10"}, rd_plane, exp_rd());
      chk({tag, " rows R11"}, {{(N-ROWS){1'b0}}, row_or}, {{(N-ROWS){1'b0}}, er});
      chk({tag, " cols R11"}, {{(N-COLS){1'b0}}, col_or}, {{(N-COLS){1'b0}}, ec});
   endtask

   // apply current inputs to the model, clock once, compare
   task automatic step(string tag);
      bit [N-1:0] nq, nc, na;
      for (int i = 0; i < N; i++) begin
         bit o, s, cy;
         case (opnd_sel)
            3'd0:    o = mm[i][mem_addr];
            3'd1:    o = mq[i];
            3'd2:    o = ma[i];
            3'd3:    o = mc[nbr_idx(i, nbr_dir)];
            3'd4:    o = bcast_bit;
            default: o = 1'b0;
         endcase
         s  = mq[i] ^ mc[i] ^ o;
         cy = (mq[i] & mc[i]) | (mq[i] & o) | (mc[i] & o);
         nq[i] = mq[i];
         nc[i] = mc[i];
         na[i] = ma[i];
         if (op_valid) begin
            case (q_ctl)
               2'd1: nq[i] = s;
               2'd2: nq[i] = o;
               2'd3: nq[i] = 1'b0;
               default: ;
            endcase
            case (c_ctl)
               2'd1: nc[i] = cy;
               2'd2: nc[i] = 1'b0;
               2'd3: nc[i] = 1'b1;
               default: ;
            endcase
            case (a_ctl)
               2'd1: na[i] = o;
               2'd2: na[i] = 1'b1;
               2'd3: na[i] = 1'b0;
               default: ;
            endcase
         end
         if (io_wr_en)
            mm[i][mem_addr] = io_wr_data[i];
         else if (op_valid && wr_en && ma[i])
            mm[i][mem_addr] = wr_src ? o : s;
      end
      mq = nq;
      mc = nc;
      ma = na;
      @(posedge clk);
      #1;
      compare(tag);
   endtask

   task automatic idle();
      op_valid = 0; opnd_sel = 0; nbr_dir = 0; bcast_bit = 0; q_ctl = 0;
      c_ctl = 0; a_ctl = 0; wr_en = 0; wr_src = 0; io_wr_en = 0;
      io_wr_data = '0;
   endtask

   task automatic op(logic [2:0] os, logic [1:0] nd, logic bb, logic [AW-1:0] ad,
                     logic [1:0] qc, logic [1:0] cc, logic [1:0] ac,
                     logic we, logic ws, string tag);
      idle();
      op_valid = 1; opnd_sel = os; nbr_dir = nd; bcast_bit = bb; mem_addr = ad;
      q_ctl = qc; c_ctl = cc; a_ctl = ac; wr_en = we; wr_src = ws;
      step(tag);
   endtask

   task automatic load(logic [AW-1:0] ad, logic [N-1:0] d, string tag);
      idle();
      mem_addr = ad; io_wr_en = 1; io_wr_data = d;
      step(tag);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      idle();
      mem_addr = '0;
      obs_sel  = 2'd0;
      rst_n    = 0;
      mq = '0; mc = '0; ma = '1;
      for (int i = 0; i < N; i++) mm[i] = '0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1;
      // R1: reset state
      compare("R1 reset");
      obs_sel = 2'd2;
      #1 compare("R1 reset A bus");

      // R9 plane loads into every address, then idle readback (R8, R10)
      for (int a = 0; a < DEPTH; a++) load(AW'(a), N'($urandom), "R9 load");
      for (int a = 0; a < DEPTH; a++) begin
         idle();
         mem_addr = AW'(a);
         obs_sel  = 2'(a);
         step("R8 idle readback");
      end

      // R4: single C bit at an edge element moved in each direction
      obs_sel = 2'd1;
      load(4'd0, 16'h0008, "R9 seed");
      op(3'd0, 2'd0, 0, 4'd0, 2'd2, 2'd2, 2'd0, 0, 0, "R7 Q from mem");
      op(3'd0, 2'd0, 0, 4'd0, 2'd0, 2'd1, 2'd0, 0, 0, "R2 C carry");
      for (int d = 0; d < 4; d++)
         op(3'd3, 2'(d), 0, 4'd0, 2'd2, 2'd0, 2'd0, 0, 0, "R4 neighbour");
      op(3'd3, 2'd1, 0, 4'd1, 2'd2, 2'd0, 2'd0, 1, 1, "R4 R6 store nbr");

      // R5: mask from a pattern plane
      load(4'd2, 16'hA5C3, "R9 mask plane");
      op(3'd0, 2'd0, 0, 4'd2, 2'd0, 2'd0, 2'd1, 0, 0, "R7 A from mem");
      op(3'd4, 2'd0, 1, 4'd3, 2'd0, 2'd0, 2'd0, 1, 1, "R5 masked write");
      op(3'd4, 2'd0, 0, 4'd2, 2'd1, 2'd3, 2'd3, 1, 0, "R5 sum write, A cleared");
      op(3'd4, 2'd0, 1, 4'd2, 2'd0, 2'd0, 2'd0, 1, 1, "R5 all masked");
      // R9 ignores A and overrides an instruction write
      idle();
      op_valid = 1; opnd_sel = 3'd4; bcast_bit = 1; mem_addr = 4'd4;
      wr_en = 1; wr_src = 1; a_ctl = 2'd2; io_wr_en = 1; io_wr_data = 16'h1234;
      step("R9 override");
      // R3 unused operand codes
      for (int k = 5; k < 8; k++)
         op(3'(k), 2'd0, 1, 4'd4, 2'd2, 2'd1, 2'd1, 1, 1, "R3 unused code");
      op(3'd1, 2'd0, 0, 4'd4, 2'd1, 2'd1, 2'd0, 1, 0, "R3 Q operand");
      op(3'd2, 2'd0, 0, 4'd4, 2'd2, 2'd0, 2'd0, 1, 1, "R3 A operand");

      // random sweep over all codes
      for (int t = 0; t < 4000; t++) begin
         idle();
         op_valid   = ($urandom % 8) != 0;
         opnd_sel   = 3'($urandom);
         nbr_dir    = 2'($urandom);
         bcast_bit  = 1'($urandom);
         mem_addr   = AW'($urandom);
         q_ctl      = 2'($urandom);
         c_ctl      = 2'($urandom);
         a_ctl      = (($urandom % 4) == 0) ? 2'($urandom) : 2'd0;
         wr_en      = 1'($urandom);
         wr_src     = 1'($urandom);
         io_wr_en   = ($urandom % 16) == 0;
         io_wr_data = N'($urandom);
         obs_sel    = 2'($urandom);
         step("R2 R3 R4 R5 R6 R7 random");
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule